// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, frame by frame, whether the frame should be kept. It watches the first six bytes of each frame, which carry the 48-bit destination address, as a byte stream qualified by a valid flag and a start-of-frame marker. While the bytes arrive it runs a byte-wide reflected CRC-32 over them. The result gives a 6-bit index into a 64-bin multicast hash bitmap.

One cycle after the sixth address byte, the block pulses a decision strobe together with an accept flag and a reason code. The address is tested against these, in priority order:
- promiscuous mode
- the broadcast address
- a parameterised table of exact-match unicast entries, each with its own valid bit
- a pass-all-multicast override
- the multicast hash lookup

A plain write port loads the mode bits, the two 32-bit hash words and the exact-match entries. Entry 0 is meant for the station's own address, and further entries hold additional unicast addresses.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the decision outputs are low, the mode bits and hash words are zero, and every exact-match entry is invalid, so any non-broadcast address is dropped (reason 0).
- R2: `dec_vld` is high for exactly one cycle, in the cycle after the clock edge that captures the sixth address byte. During that cycle `dec_accept` is 1 for every reason code except 0. Outside it, `dec_accept` and `dec_reason` are 0.
- R3: With mode bit 0 (promiscuous) set, every frame is accepted with reason 1.
- R4: With promiscuous mode off, the all-ones address is accepted with reason 2.
- R5: Write address 4+2k loads bytes 0..3 of entry k, with the first received byte in bits 7:0. Write address 5+2k loads bytes 4..5 in bits 15:0 and the valid flag in bit 31. A destination equal to a valid entry is accepted with reason 3. Invalid entries never match.
- R6: With mode bit 1 (pass-all-multicast) set, any multicast destination is accepted with reason 4, without consulting the hash words. A destination is multicast when bit 0 of its first byte is 1.
- R7: The CRC-32 is computed over the six address bytes, in reflected form, starting from all ones. Its final value is complemented and bit-reversed, and the top 6 bits of that form the index. Index bit 5 selects the hash word: write address 1 is low, write address 2 is high. Index bits 4:0 select the bit within that word. With mode bit 2 (hash) set, a multicast destination whose selected bit is 1 is accepted with reason 5.
- R8: With mode bit 2 clear, the hash words never accept a frame. A multicast destination with its selected hash bit 0, and no other rule applying, is dropped with reason 0.
- R9: A byte with start-of-frame set restarts address capture and the CRC, discarding any partly received address. No decision is issued for the abandoned frame.
- R10: Idle cycles between address bytes are tolerated. Bytes after the sixth, and bytes that arrive without a preceding start-of-frame, do not produce decisions.
- R11: The rules have a fixed priority: promiscuous, then broadcast, then exact match, then pass-all-multicast, then hash. The first rule that applies sets the reason code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | First byte of a frame, qualified by byte_vld |
| byte_vld | input | 1 | byte_data carries a frame byte this cycle |
| byte_data | input | 8 | Received frame byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W (4) | Write address: 0 mode, 1/2 hash words, 4+2k/5+2k entry k |
| cfg_wdata | input | 32 | Configuration write data |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 drop, 1 promiscuous, 2 broadcast, 3 exact, 4 pass-all-multicast, 5 hash |

## Verification
Every decision depends on the captured address, the CRC register and the byte counter. A corrupted CRC moves the hash index, which shows as a wrong accept or drop on a multicast frame at the very next strobe. A byte counter that is off by one, or that fails to restart, shows as a missing, early or repeated strobe within a few cycles of the sixth byte. A wrongly captured byte turns an exact match into a drop. Tests are therefore arranged so that each address, and each partially received frame, ends in a strobe whose timing and reason code pin down the fault.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int N_EXACT = 4,
  parameter int ADDR_W  = $clog2(2 * N_EXACT + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              dec_vld,
  output logic              dec_accept,
  output logic [2:0]        dec_reason
);

  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [2:0] RSN_DROP    = 3'd0;
  localparam logic [2:0] RSN_PROMISC = 3'd1;
  localparam logic [2:0] RSN_BCAST   = 3'd2;
  localparam logic [2:0] RSN_EXACT   = 3'd3;
  localparam logic [2:0] RSN_PASSMC  = 3'd4;
  localparam logic [2:0] RSN_HASH    = 3'd5;

  logic [2:0]         mode_q;
  logic [31:0]        hash_lo_q, hash_hi_q;
  logic [47:0]        da_q;
  logic [31:0]        crc_q;
  logic [2:0]         cnt_q;
  logic               done_q;
  logic [N_EXACT-1:0] hit, ent_valid;
  logic [2:0]         reason;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire        start    = byte_vld && sof;
  wire        take     = byte_vld && (start || (cnt_q != 3'd0 && cnt_q < 3'd6));
  wire [2:0]  slot     = start ? 3'd0 : cnt_q;
  wire [31:0] crc_base = start ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= 3'd0;
      crc_q  <= 32'hFFFF_FFFF;
      da_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && (slot == 3'd5);
      if (take) begin
        crc_q <= crc_byte(crc_base, byte_data);
        da_q[slot*8 +: 8] <= byte_data;
        cnt_q <= slot + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      hash_lo_q <= '0;
      hash_hi_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(0)) mode_q    <= cfg_wdata[2:0];
      if (cfg_addr == ADDR_W'(1)) hash_lo_q <= cfg_wdata;
      if (cfg_addr == ADDR_W'(2)) hash_hi_q <= cfg_wdata;
    end
  end

  for (genvar k = 0; k < N_EXACT; k++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        v_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        v_q  <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(4 + 2 * k)) lo_q <= cfg_wdata;
        if (cfg_addr == ADDR_W'(5 + 2 * k)) begin
          hi_q <= cfg_wdata[15:0];
          v_q  <= cfg_wdata[31];
        end
      end
    end
    assign ent_valid[k] = v_q;
    assign hit[k]       = v_q && (da_q == {hi_q, lo_q});
  end

  wire       is_mc    = da_q[0];
  wire       is_bc    = &da_q;
  wire [5:0] hidx     = ~{crc_q[0], crc_q[1], crc_q[2], crc_q[3], crc_q[4], crc_q[5]};
  wire       hash_bit = hidx[5] ? hash_hi_q[hidx[4:0]] : hash_lo_q[hidx[4:0]];

  always_comb begin
    if (mode_q[0])                         reason = RSN_PROMISC;
    else if (is_bc)                        reason = RSN_BCAST;
    else if (|hit)                         reason = RSN_EXACT;
    else if (is_mc && mode_q[1])           reason = RSN_PASSMC;
    else if (is_mc && mode_q[2] && hash_bit) reason = RSN_HASH;
    else                                   reason = RSN_DROP;
  end

  assign dec_vld    = done_q;
  assign dec_reason = done_q ? reason : RSN_DROP;
  assign dec_accept = done_q && (reason != RSN_DROP);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
  assert_strobe_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> (!dec_accept && dec_reason == RSN_DROP));
  assert_promisc_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && mode_q[0]) |-> dec_reason == RSN_PROMISC);
  assert_hash_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_reason == RSN_HASH) |-> (mode_q[2] && da_q[0]));
  assert_exact_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_reason == RSN_EXACT) |-> (|ent_valid));

endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic clk = 0, rst_n = 0, sof = 0, byte_vld = 0, cfg_we = 0;
  logic [7:0] byte_data = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic dec_vld, dec_accept;
  logic [2:0] dec_reason;
  int checks = 0, errors = 0;

  localparam logic [47:0] OWN  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTH  = 48'h02_AA_BB_CC_DD_01;
  localparam logic [47:0] UNK  = 48'h02_00_00_00_00_99;
  localparam logic [47:0] MC1  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC2  = 48'h33_33_00_00_00_01;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

  always #10 clk = ~clk;

  rx_addr_filter u0 (.clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_reason(dec_reason));

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ a[47 - 8*i - 7 + b];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return ~c[31:26];
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_entry(input int k, input logic [47:0] a, input logic v);
    wr(4 + 2*k, {a[23:16], a[31:24], a[39:32], a[47:40]});
    wr(5 + 2*k, {v, 15'd0, a[7:0], a[15:8]});
  endtask

  task automatic set_hash_only(input logic [5:0] ix, input logic invert);
    logic [63:0] m = 64'd1 << ix;
    if (invert) m = ~m;
    wr(1, m[31:0]); wr(2, m[63:32]);
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sof = (i == 0); byte_vld = 1; byte_data = a[47-8*i -: 8];
      if (i < 5)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); sof = 0; byte_vld = 0;
          chk("R10 no early strobe", {3'd0, dec_vld}, 4'd0);
        end
    end
    @(negedge clk); sof = 0; byte_vld = 0;
  endtask

  task automatic frame(input string req, input logic [47:0] a, input logic acc, input logic [2:0] rsn);
    send(a, 0);
    chk({req, " strobe R2"}, {3'd0, dec_vld}, 4'd1);
    chk({req, " accept"}, {3'd0, dec_accept}, {3'd0, acc});
    chk({req, " reason"}, {1'b0, dec_reason}, {1'b0, rsn});
    @(negedge clk);
    chk({req, " single strobe R2"}, {3'd0, dec_vld}, 4'd0);
  endtask

  task automatic t_reset;
    chk("R1 idle vld", {3'd0, dec_vld}, 4'd0);
    chk("R1 idle reason", {1'b0, dec_reason}, 4'd0);
    frame("R1 own before config", OWN, 0, 0);
    frame("R1 mc before config", MC1, 0, 0);
  endtask

  task automatic t_exact;
    wr_entry(0, OWN, 1); wr_entry(2, OTH, 1);
    frame("R5 own", OWN, 1, 3);
    frame("R5 entry2", OTH, 1, 3);
    frame("R5 unknown", UNK, 0, 0);
    wr_entry(2, OTH, 0);
    frame("R5 invalidated", OTH, 0, 0);
  endtask

  task automatic t_bcast;
    frame("R4 broadcast", BC, 1, 2);
  endtask

  task automatic t_hash;
    logic [5:0] i1 = hidx(MC1), i2 = hidx(MC2);
    wr(0, 32'h4);
    set_hash_only(i1, 0);
    frame("R7 hash hit", MC1, 1, 5);
    frame("R7 other mc", MC2, i2 == i1, (i2 == i1) ? 3'd5 : 3'd0);
    frame("R7 unicast not hashed", UNK, 0, 0);
    set_hash_only(i1, 1);
    frame("R8 bit clear", MC1, 0, 0);
    frame("R7 other bit", MC2, i2 != i1, (i2 != i1) ? 3'd5 : 3'd0);
    wr(0, 32'h0);
    frame("R8 mode off", MC2, 0, 0);
  endtask

  task automatic t_passmc;
    wr(1, 0); wr(2, 0); wr(0, 32'h2);
    frame("R6 pass mc1", MC1, 1, 4);
    frame("R6 pass mc2", MC2, 1, 4);
    frame("R6 unicast", UNK, 0, 0);
  endtask

  task automatic t_priority;
    wr_entry(1, MC1, 1);
    frame("R11 exact over passmc", MC1, 1, 3);
    wr(0, 32'h7);
    frame("R3 promisc unknown", UNK, 1, 1);
    frame("R11 promisc over bcast", BC, 1, 1);
    frame("R11 promisc over exact", OWN, 1, 1);
    wr(0, 32'h0); wr_entry(1, MC1, 0);
  endtask

  task automatic t_restart;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sof = (i == 0); byte_vld = 1; byte_data = UNK[47-8*i -: 8];
    end
    frame("R9 restart own", OWN, 1, 3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sof = (i == 0); byte_vld = 1; byte_data = OWN[47-8*i -: 8];
    end
    @(negedge clk); sof = 1; byte_vld = 1; byte_data = UNK[47:40];
    @(negedge clk); sof = 0; byte_vld = 0;
    chk("R9 abandoned no strobe", {3'd0, dec_vld}, 4'd0);
    for (int i = 1; i < 6; i++) begin
      @(negedge clk); byte_vld = 1; byte_data = UNK[47-8*i -: 8];
    end
    @(negedge clk); byte_vld = 0;
    chk("R9 restarted strobe", {3'd0, dec_vld}, 4'd1);
    chk("R9 restarted reason", {1'b0, dec_reason}, 4'd0);
  endtask

  task automatic t_gaps;
    send(OWN, 2);
    chk("R10 gapped strobe", {3'd0, dec_vld}, 4'd1);
    chk("R10 gapped reason", {1'b0, dec_reason}, 4'd3);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byte_vld = 1; byte_data = 8'hFF;
      chk("R10 trailing bytes", {3'd0, dec_vld}, 4'd0);
    end
    @(negedge clk); byte_vld = 0;
    chk("R10 trailing quiet", {3'd0, dec_vld}, 4'd0);
    frame("R10 next frame", OTH, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_exact; t_bcast; t_hash; t_passmc; t_priority; t_restart; t_gaps;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule